// File: doc/BRIEF.md
# Receive Descriptor and Status Queue Manager

This block sits in a network receive path between the MAC's word stream and system memory. Software hands it receive buffers by adding descriptor credits. The block reads one-word descriptors from a ring in memory into a small internal FIFO. When a frame starts, the block takes the oldest fetched descriptor and loads its buffer address into a current-address register. It then writes the frame words to consecutive addresses from that point. At end of frame it writes a status word into a status ring. Software returns consumed status slots by adding status credits.

Frame words land in an internal data FIFO, so the MAC is never stalled. The MAC can fill that FIFO while earlier words are still being written to memory. Soft errors (CRC, overrun, too long, too short) only mark the frame's status, and reception goes on. A hard error (bus abort on the memory port, system error, or parity error when parity checking is on) freezes all memory traffic. Nothing moves again until software issues a channel reset and enqueues credits again.

Top module: `rqm_top`

## Requirements
- R1: A pulse on `desc_enq_wr_i` adds `desc_enq_cnt_i` to the descriptor credit count (`desc_cnt_o`) rather than replacing it.
- R2: Each completed descriptor read lowers `desc_cnt_o` by one. No read is issued while the internal descriptor FIFO (DFIFO_DEPTH entries) is full. A read that ends with a bus error is not counted.
- R3: Descriptor `i` is the word at DESC_BASE+4·i, and its content is a buffer byte address. Descriptors are used in ring order from index 0. A frame's words are written to consecutive word addresses from that buffer address. `cur_buf_addr_o` shows the address of the next word to write. A memory request, once raised, holds its address and direction until granted.
- R4: The status word for the n-th frame goes to STS_BASE+4·(n mod NSTS). Its layout is: bit 31 is the frame-processed flag (set by the block), bits 27:20 hold the buffer index, bits 19:16 hold the soft errors {short, long, overrun, CRC}, and bits 15:0 hold the length in bytes.
- R5: Each status write lowers `sts_cnt_o` by one.
- R6: A pulse on `sts_rel_wr_i` adds `sts_rel_cnt_i` to `sts_cnt_o`.
- R7: The soft-error bits given with a frame's last word appear in that frame's status, and the next frame is received normally.
- R8: A frame is dropped without any memory write in two cases: when it starts with no status credit, or when it starts with no fetched descriptor and no descriptor credit. A dropped frame consumes no descriptor. The overrun bit is then set in the next status word written. A word that arrives with the data FIFO full is lost in the same way.
- R9: `irq_o` is sticky. It is set by a status write while `frame_irq_en_i` is high, or by any hard error. A pulse on `irq_clr_i` clears it. With the enable low, a frame raises no interrupt.
- R10: A hard error sets `halted_o` and `irq_o`. While halted, no memory request is raised and incoming words are discarded. `par_err_i` counts as a hard error only when `par_chk_en_i` is high.
- R11: `chan_rst_i` clears the halt, both credit counts, both ring positions and both FIFOs. It takes priority over same-cycle credit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_enq_wr_i | input | 1 | Add descriptor credits |
| desc_enq_cnt_i | input | CW | Descriptor credits to add |
| sts_rel_wr_i | input | 1 | Add status credits |
| sts_rel_cnt_i | input | CW | Status credits to add |
| chan_rst_i | input | 1 | Receive channel reset |
| irq_clr_i | input | 1 | Clear interrupt |
| frame_irq_en_i | input | 1 | Interrupt on each status write |
| par_chk_en_i | input | 1 | Treat parity errors as hard errors |
| rxd_valid_i | input | 1 | Receive word valid |
| rxd_data_i | input | DW | Receive word |
| rxd_bytes_i | input | log2(DW/8)+1 | Valid bytes in word |
| rxd_last_i | input | 1 | Last word of frame |
| rxd_err_i | input | 4 | Soft errors, valid with last word |
| par_err_i | input | 1 | Parity error |
| sys_err_i | input | 1 | System error |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Request completes this cycle |
| mem_err_i | input | 1 | Completion is an abort |
| mem_rdata_i | input | DW | Read data, valid with grant |
| desc_cnt_o | output | CW | Descriptor credits |
| sts_cnt_o | output | CW | Status credits |
| cur_buf_addr_o | output | AW | Current buffer write address |
| halted_o | output | 1 | Halted by hard error |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check the credit arithmetic on every cycle: additions, decrements on descriptor reads and status writes, and both at once. They also check that a pending memory request holds steady, that nothing is requested while halted, that a halt always comes with an interrupt, and that a channel reset clears state. What lands in memory can only be shown by the bench's scenarios. That covers ring order, buffer placement, the packing of each status word, the overrun carried over from a dropped frame, and resumption after reset.

// File: rtl/rqm_pkg.sv
package rqm_pkg;
  localparam int ERR_W     = 4;
  localparam int ERR_CRC   = 0;
  localparam int ERR_OVR   = 1;
  localparam int ERR_LONG  = 2;
  localparam int ERR_SHORT = 3;

  localparam int STS_LEN_W    = 16;
  localparam int STS_ERR_LSB  = 16;
  localparam int STS_IDX_LSB  = 20;
  localparam int STS_IDX_W    = 8;
  localparam int STS_DONE_BIT = 31;

  typedef enum logic [1:0] {OWN_NONE, OWN_FETCH, OWN_DMA} owner_e;
  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_DROP, ST_STAT} dma_st_e;
endpackage

// File: rtl/rqm_fifo.sv
module rqm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem_q [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [CNW-1:0] cnt_q;
  logic           do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CNW'(do_push) - CNW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/rqm_credit.sv
module rqm_credit #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [CW-1:0] add_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + (add_i ? add_val_i : '0) - CW'(dec_i);
  end
endmodule

// File: rtl/rqm_fetch.sv
module rqm_fetch #(
  parameter int            AW        = 32,
  parameter int            NDESC     = 16,
  parameter int            IW        = 4,
  parameter logic [AW-1:0] DESC_BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          credit_nz_i,
  input  logic          slot_free_i,
  input  logic          done_i,
  input  logic [AW-1:0] rdata_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [IW-1:0] buf_idx_o
);
  logic [IW-1:0] idx_q;

  assign req_o      = credit_nz_i && slot_free_i;
  assign addr_o     = DESC_BASE + AW'({idx_q, 2'b00});
  assign buf_addr_o = rdata_i;
  assign buf_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (flush_i) idx_q <= '0;
    else if (done_i)  idx_q <= (idx_q == IW'(NDESC - 1)) ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/rqm_dma.sv
module rqm_dma import rqm_pkg::*; #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            IW       = 4,
  parameter int            BW       = 3,
  parameter int            NSTS     = 16,
  parameter logic [AW-1:0] STS_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             run_i,
  input  logic             dq_empty_i,
  input  logic [DW-1:0]    dq_data_i,
  input  logic [BW-1:0]    dq_bytes_i,
  input  logic             dq_last_i,
  input  logic [ERR_W-1:0] dq_err_i,
  output logic             dq_pop_o,
  input  logic             df_empty_i,
  input  logic [AW-1:0]    df_addr_i,
  input  logic [IW-1:0]    df_idx_i,
  output logic             df_pop_o,
  input  logic             sts_nz_i,
  input  logic             desc_nz_i,
  input  logic             ovf_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             sts_done_o,
  output logic [AW-1:0]    cur_addr_o
);
  localparam int SW = (NSTS > 1) ? $clog2(NSTS) : 1;

  dma_st_e              st_q, st_d;
  logic [AW-1:0]        cur_q;
  logic [IW-1:0]        idx_q;
  logic [STS_LEN_W-1:0] len_q;
  logic [ERR_W-1:0]     err_q;
  logic                 pend_q;
  logic [SW-1:0]        sidx_q;
  logic                 drop_start;
  logic [DW-1:0]        sts_word;

  assign cur_addr_o = cur_q;

  always_comb begin
    sts_word = '0;
    sts_word[STS_DONE_BIT] = 1'b1;
    sts_word[STS_IDX_LSB +: STS_IDX_W] = STS_IDX_W'(idx_q);
    sts_word[STS_ERR_LSB +: ERR_W] = err_q | (pend_q ? ERR_W'(1 << ERR_OVR) : '0);
    sts_word[STS_LEN_W-1:0] = len_q;
  end

  always_comb begin
    st_d       = st_q;
    dq_pop_o   = 1'b0;
    df_pop_o   = 1'b0;
    req_o      = 1'b0;
    addr_o     = cur_q;
    wdata_o    = dq_data_i;
    sts_done_o = 1'b0;
    drop_start = 1'b0;
    unique case (st_q)
      ST_IDLE: if (run_i && !dq_empty_i) begin
        if (!sts_nz_i || (df_empty_i && !desc_nz_i)) begin
          st_d       = ST_DROP;
          drop_start = 1'b1;
        end else if (!df_empty_i) begin
          df_pop_o = 1'b1;
          st_d     = ST_STORE;
        end
      end
      ST_STORE: begin
        req_o = run_i && !dq_empty_i;
        if (done_i) begin
          dq_pop_o = 1'b1;
          if (dq_last_i) st_d = ST_STAT;
        end
      end
      ST_DROP: if (run_i && !dq_empty_i) begin
        dq_pop_o = 1'b1;
        if (dq_last_i) st_d = ST_IDLE;
      end
      ST_STAT: begin
        req_o   = run_i;
        addr_o  = STS_BASE + AW'({sidx_q, 2'b00});
        wdata_o = sts_word;
        if (done_i) begin
          sts_done_o = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      err_q  <= '0;
      pend_q <= 1'b0;
      sidx_q <= '0;
    end else if (flush_i) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      err_q  <= '0;
      pend_q <= 1'b0;
      sidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (df_pop_o) begin
        cur_q <= df_addr_i;
        idx_q <= df_idx_i;
        len_q <= '0;
        err_q <= '0;
      end else if (st_q == ST_STORE && done_i) begin
        cur_q <= cur_q + AW'(DW / 8);
        len_q <= len_q + STS_LEN_W'(dq_bytes_i);
        err_q <= err_q | dq_err_i;
      end
      // overrun flag survives until a status word carries it
      if (drop_start || ovf_i) pend_q <= 1'b1;
      else if (sts_done_o)     pend_q <= 1'b0;
      if (sts_done_o) sidx_q <= (sidx_q == SW'(NSTS - 1)) ? '0 : sidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/rqm_top.sv
module rqm_top import rqm_pkg::*; #(
  parameter int            AW          = 32,
  parameter int            DW          = 32,
  parameter int            CW          = 16,
  parameter int            NDESC       = 16,
  parameter int            NSTS        = 16,
  parameter int            DFIFO_DEPTH = 4,
  parameter int            DATA_DEPTH  = 16,
  parameter logic [AW-1:0] DESC_BASE   = 'h0,
  parameter logic [AW-1:0] STS_BASE    = 'h100
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     desc_enq_wr_i,
  input  logic [CW-1:0]            desc_enq_cnt_i,
  input  logic                     sts_rel_wr_i,
  input  logic [CW-1:0]            sts_rel_cnt_i,
  input  logic                     chan_rst_i,
  input  logic                     irq_clr_i,
  input  logic                     frame_irq_en_i,
  input  logic                     par_chk_en_i,
  input  logic                     rxd_valid_i,
  input  logic [DW-1:0]            rxd_data_i,
  input  logic [$clog2(DW/8):0]    rxd_bytes_i,
  input  logic                     rxd_last_i,
  input  logic [ERR_W-1:0]         rxd_err_i,
  input  logic                     par_err_i,
  input  logic                     sys_err_i,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic                     mem_gnt_i,
  input  logic                     mem_err_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic [CW-1:0]            desc_cnt_o,
  output logic [CW-1:0]            sts_cnt_o,
  output logic [AW-1:0]            cur_buf_addr_o,
  output logic                     halted_o,
  output logic                     irq_o
);
  localparam int BW   = $clog2(DW / 8) + 1;
  localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1;
  localparam int DQ_W = DW + BW + 1 + ERR_W;
  localparam int DF_W = AW + IW;

  logic            halted_q, irq_q;
  owner_e          own_q;
  logic            hard_now, xfer_ok, dma_done, fetch_done, sts_done;
  logic            sel_dma, sel_fetch;

  // receive data FIFO
  logic            dq_push, dq_pop, dq_empty, dq_full, ovf;
  logic [DQ_W-1:0] dq_rdata;
  logic [DW-1:0]   dq_data;
  logic [BW-1:0]   dq_bytes;
  logic            dq_last;
  logic [ERR_W-1:0] dq_err;

  assign dq_push = rxd_valid_i && !halted_q && !chan_rst_i;
  assign ovf     = dq_push && dq_full;
  assign {dq_data, dq_bytes, dq_last, dq_err} = dq_rdata;

  rqm_fifo #(.W(DQ_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk_i, .rst_ni, .flush_i(chan_rst_i),
    .push_i(dq_push), .wdata_i({rxd_data_i, rxd_bytes_i, rxd_last_i, rxd_err_i}),
    .pop_i(dq_pop), .rdata_o(dq_rdata), .empty_o(dq_empty), .full_o(dq_full)
  );

  // descriptor credits, fetcher, descriptor FIFO
  logic            fetch_req;
  logic [AW-1:0]   fetch_addr, fetch_buf;
  logic [IW-1:0]   fetch_idx;
  logic            df_pop, df_empty, df_full;
  logic [DF_W-1:0] df_rdata;
  logic [AW-1:0]   df_addr;
  logic [IW-1:0]   df_idx;

  assign {df_addr, df_idx} = df_rdata;

  rqm_credit #(.CW(CW)) u_desc_credit (
    .clk_i, .rst_ni, .clr_i(chan_rst_i), .add_i(desc_enq_wr_i),
    .add_val_i(desc_enq_cnt_i), .dec_i(fetch_done), .cnt_o(desc_cnt_o)
  );

  rqm_fetch #(.AW(AW), .NDESC(NDESC), .IW(IW), .DESC_BASE(DESC_BASE)) u_fetch (
    .clk_i, .rst_ni, .flush_i(chan_rst_i),
    .credit_nz_i(desc_cnt_o != '0), .slot_free_i(!df_full), .done_i(fetch_done),
    .rdata_i(mem_rdata_i[AW-1:0]), .req_o(fetch_req), .addr_o(fetch_addr),
    .buf_addr_o(fetch_buf), .buf_idx_o(fetch_idx)
  );

  rqm_fifo #(.W(DF_W), .DEPTH(DFIFO_DEPTH)) u_desc_fifo (
    .clk_i, .rst_ni, .flush_i(chan_rst_i),
    .push_i(fetch_done), .wdata_i({fetch_buf, fetch_idx}),
    .pop_i(df_pop), .rdata_o(df_rdata), .empty_o(df_empty), .full_o(df_full)
  );

  // status credits and frame engine
  logic            dma_req;
  logic [AW-1:0]   dma_addr;
  logic [DW-1:0]   dma_wdata;

  rqm_credit #(.CW(CW)) u_sts_credit (
    .clk_i, .rst_ni, .clr_i(chan_rst_i), .add_i(sts_rel_wr_i),
    .add_val_i(sts_rel_cnt_i), .dec_i(sts_done), .cnt_o(sts_cnt_o)
  );

  rqm_dma #(.AW(AW), .DW(DW), .IW(IW), .BW(BW), .NSTS(NSTS), .STS_BASE(STS_BASE)) u_dma (
    .clk_i, .rst_ni, .flush_i(chan_rst_i), .run_i(!halted_q),
    .dq_empty_i(dq_empty), .dq_data_i(dq_data), .dq_bytes_i(dq_bytes),
    .dq_last_i(dq_last), .dq_err_i(dq_err), .dq_pop_o(dq_pop),
    .df_empty_i(df_empty), .df_addr_i(df_addr), .df_idx_i(df_idx), .df_pop_o(df_pop),
    .sts_nz_i(sts_cnt_o != '0), .desc_nz_i(desc_cnt_o != '0), .ovf_i(ovf),
    .done_i(dma_done), .req_o(dma_req), .addr_o(dma_addr), .wdata_o(dma_wdata),
    .sts_done_o(sts_done), .cur_addr_o(cur_buf_addr_o)
  );

  // memory port: frame engine first, owner locked until grant
  always_comb begin
    sel_dma   = (own_q == OWN_DMA) || (own_q == OWN_NONE && dma_req);
    sel_fetch = (own_q == OWN_FETCH) || (own_q == OWN_NONE && !dma_req && fetch_req);
  end

  assign mem_req_o   = !halted_q && ((sel_dma && dma_req) || (sel_fetch && fetch_req));
  assign mem_we_o    = sel_dma;
  assign mem_addr_o  = sel_dma ? dma_addr : fetch_addr;
  assign mem_wdata_o = dma_wdata;

  assign hard_now   = sys_err_i || (par_chk_en_i && par_err_i) ||
                      (mem_req_o && mem_gnt_i && mem_err_i);
  assign xfer_ok    = mem_req_o && mem_gnt_i && !hard_now;
  assign dma_done   = xfer_ok && sel_dma;
  assign fetch_done = xfer_ok && sel_fetch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q    <= OWN_NONE;
      halted_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (chan_rst_i || hard_now)     own_q <= OWN_NONE;
      else if (mem_req_o && !mem_gnt_i) own_q <= sel_dma ? OWN_DMA : OWN_FETCH;
      else                            own_q <= OWN_NONE;
      halted_q <= chan_rst_i ? 1'b0 : (halted_q || hard_now);
      irq_q    <= (irq_q && !irq_clr_i) || hard_now || (sts_done && frame_irq_en_i);
    end
  end

  assign halted_o = halted_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rqm_checker.sv
module rqm_checker #(
  parameter int            AW       = 32,
  parameter int            CW       = 16,
  parameter int            NSTS     = 16,
  parameter logic [AW-1:0] STS_BASE = 'h100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          desc_enq_wr_i,
  input logic [CW-1:0] desc_enq_cnt_i,
  input logic          sts_rel_wr_i,
  input logic [CW-1:0] sts_rel_cnt_i,
  input logic          chan_rst_i,
  input logic          par_chk_en_i,
  input logic          par_err_i,
  input logic          sys_err_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_gnt_i,
  input logic          mem_err_i,
  input logic [CW-1:0] desc_cnt_o,
  input logic [CW-1:0] sts_cnt_o,
  input logic          halted_o,
  input logic          irq_o
);
  logic hard, rd_done, sts_wr_done, in_sts;

  assign hard        = sys_err_i || (par_chk_en_i && par_err_i) || (mem_req_o && mem_gnt_i && mem_err_i);
  assign in_sts      = (mem_addr_o >= STS_BASE) && (mem_addr_o < STS_BASE + AW'(4 * NSTS));
  assign rd_done     = mem_req_o && mem_gnt_i && !mem_we_o && !hard;
  assign sts_wr_done = mem_req_o && mem_gnt_i && mem_we_o && in_sts && !hard;

  assert_desc_add_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_enq_wr_i && !chan_rst_i) |=>
      desc_cnt_o == $past(desc_cnt_o + desc_enq_cnt_i - CW'(rd_done)));

  assert_desc_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && !desc_enq_wr_i && !chan_rst_i) |=> desc_cnt_o == $past(desc_cnt_o) - 1'b1);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !chan_rst_i && !sys_err_i && !(par_chk_en_i && par_err_i)) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_sts_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_done && !sts_rel_wr_i && !chan_rst_i) |=> sts_cnt_o == $past(sts_cnt_o) - 1'b1);

  assert_sts_add_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_rel_wr_i && !chan_rst_i) |=>
      sts_cnt_o == $past(sts_cnt_o + sts_rel_cnt_i - CW'(sts_wr_done)));

  assert_halt_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> irq_o);

  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o);

  assert_chan_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> (!halted_o && desc_cnt_o == '0 && sts_cnt_o == '0));
endmodule

bind rqm_top rqm_checker #(.AW(AW), .CW(CW), .NSTS(NSTS), .STS_BASE(STS_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .desc_enq_wr_i(desc_enq_wr_i), .desc_enq_cnt_i(desc_enq_cnt_i),
  .sts_rel_wr_i(sts_rel_wr_i), .sts_rel_cnt_i(sts_rel_cnt_i),
  .chan_rst_i(chan_rst_i), .par_chk_en_i(par_chk_en_i), .par_err_i(par_err_i),
  .sys_err_i(sys_err_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_err_i(mem_err_i),
  .desc_cnt_o(desc_cnt_o), .sts_cnt_o(sts_cnt_o), .halted_o(halted_o), .irq_o(irq_o)
);

// File: tb/rqm_top_tb_top.sv
module rqm_top_tb_top;
  localparam int AW = 32, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          desc_wr = 0, sts_wr = 0, chan_rst = 0, irq_clr = 0, irq_en = 0, par_en = 0;
  logic [CW-1:0] desc_n = 0, sts_n = 0;
  logic          rx_v = 0, rx_last = 0, par_err = 0, sys_err = 0;
  logic [DW-1:0] rx_d = 0;
  logic [2:0]    rx_b = 0;
  logic [3:0]    rx_e = 0;
  logic          mem_req, mem_we, mem_gnt, mem_err, halted, irq;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] desc_cnt, sts_cnt;

  logic gnt_en = 1, err_en = 0, init_req = 0;
  logic [31:0] mem [256];
  int halted_reqs = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  assign mem_gnt   = mem_req && gnt_en;
  assign mem_err   = err_en;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i < 4) ? 32'h200 + 32'h40 * i : 32'h0;
    end else if (mem_req && mem_gnt && mem_we && !mem_err) begin
      mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (halted && mem_req) halted_reqs <= halted_reqs + 1;
  end

  rqm_top #(.AW(AW), .DW(DW), .CW(CW), .NDESC(4), .NSTS(4), .DFIFO_DEPTH(4),
            .DATA_DEPTH(16), .DESC_BASE('h0), .STS_BASE('h100)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_enq_wr_i(desc_wr), .desc_enq_cnt_i(desc_n),
    .sts_rel_wr_i(sts_wr), .sts_rel_cnt_i(sts_n),
    .chan_rst_i(chan_rst), .irq_clr_i(irq_clr), .frame_irq_en_i(irq_en),
    .par_chk_en_i(par_en), .rxd_valid_i(rx_v), .rxd_data_i(rx_d), .rxd_bytes_i(rx_b),
    .rxd_last_i(rx_last), .rxd_err_i(rx_e), .par_err_i(par_err), .sys_err_i(sys_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .desc_cnt_o(desc_cnt), .sts_cnt_o(sts_cnt), .cur_buf_addr_o(cur_addr),
    .halted_o(halted), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chan_reset();
    @(negedge clk); chan_rst = 1; init_req = 1;
    @(negedge clk); chan_rst = 0; init_req = 0;
  endtask

  task automatic enq_desc(input int n);
    @(negedge clk); desc_wr = 1; desc_n = CW'(n);
    @(negedge clk); desc_wr = 0;
  endtask

  task automatic rel_sts(input int n);
    @(negedge clk); sts_wr = 1; sts_n = CW'(n);
    @(negedge clk); sts_wr = 0;
  endtask

  task automatic send_frame(input int nw, input int lastb, input logic [3:0] err, input logic [31:0] seed);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      rx_v = 1; rx_d = seed + i; rx_last = (i == nw - 1);
      rx_b = (i == nw - 1) ? 3'(lastb) : 3'd4;
      rx_e = (i == nw - 1) ? err : 4'h0;
    end
    @(negedge clk); rx_v = 0; rx_last = 0; rx_e = 0;
    cyc(30);
  endtask

  function automatic logic [31:0] sts_exp(input int idx, input logic [3:0] err, input int len);
    return 32'h8000_0000 | (32'(idx) << 20) | (32'(err) << 16) | 32'(len);
  endfunction

  task automatic t_reset();
    chk("R11 reset desc_cnt", 32'(desc_cnt), 0);
    chk("R11 reset sts_cnt", 32'(sts_cnt), 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R10 reset halted", 32'(halted), 0);
  endtask

  task automatic t_credits();
    chan_reset();
    gnt_en = 0;
    enq_desc(3);
    enq_desc(2);
    chk("R1 additive enqueue", 32'(desc_cnt), 5);
    gnt_en = 1;
    cyc(20);
    chk("R2 fetch stops at FIFO depth", 32'(desc_cnt), 1);
  endtask

  task automatic t_frames();
    chan_reset();
    enq_desc(2);
    rel_sts(2);
    send_frame(3, 2, 4'h0, 32'hA000_0000);
    chk("R3 word0 buf0", mem[8'h80], 32'hA000_0000);
    chk("R3 word2 buf0", mem[8'h82], 32'hA000_0002);
    chk("R3 cur addr", cur_addr, 32'h20C);
    chk("R4 status slot0", mem[8'h40], sts_exp(0, 4'h0, 10));
    chk("R5 sts credit dec", 32'(sts_cnt), 1);
    send_frame(1, 4, 4'h0, 32'hB000_0000);
    chk("R3 ring order buf1", mem[8'h90], 32'hB000_0000);
    chk("R4 status slot1", mem[8'h41], sts_exp(1, 4'h0, 4));
    chk("R5 sts credit zero", 32'(sts_cnt), 0);
    rel_sts(2);
    chk("R6 release adds", 32'(sts_cnt), 2);
  endtask

  task automatic t_soft_err();
    chan_reset();
    enq_desc(2);
    rel_sts(2);
    send_frame(2, 4, 4'b0001, 32'hC000_0000);
    chk("R7 crc in status", mem[8'h40], sts_exp(0, 4'b0001, 8));
    send_frame(2, 3, 4'h0, 32'hD000_0000);
    chk("R7 next frame stored", mem[8'h91], 32'hD000_0001);
    chk("R7 next status clean", mem[8'h41], sts_exp(1, 4'h0, 7));
  endtask

  task automatic t_drop();
    chan_reset();
    enq_desc(2);
    send_frame(2, 4, 4'h0, 32'hE000_0000);
    chk("R8 no status credit no write", mem[8'h80], 32'h0);
    rel_sts(1);
    send_frame(1, 4, 4'h0, 32'hF000_0000);
    chk("R8 buffer not consumed", mem[8'h80], 32'hF000_0000);
    chk("R8 overrun flagged", mem[8'h40], sts_exp(0, 4'b0010, 4));
    chan_reset();
    rel_sts(2);
    send_frame(1, 4, 4'h0, 32'h1111_0000);
    chk("R8 no descriptor no write", mem[8'h80], 32'h0);
    enq_desc(1);
    cyc(5);
    send_frame(1, 2, 4'h0, 32'h2222_0000);
    chk("R8 overrun after desc drop", mem[8'h40], sts_exp(0, 4'b0010, 2));
    chk("R8 one status used", 32'(sts_cnt), 1);
  endtask

  task automatic t_irq();
    chan_reset();
    enq_desc(2);
    rel_sts(2);
    irq_en = 0;
    send_frame(1, 4, 4'h0, 32'h3000_0000);
    chk("R9 no irq when disabled", 32'(irq), 0);
    irq_en = 1;
    send_frame(1, 4, 4'h0, 32'h3100_0000);
    chk("R9 irq on status", 32'(irq), 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R9 irq cleared", 32'(irq), 0);
    irq_en = 0;
  endtask

  task automatic t_hard();
    chan_reset();
    par_en = 0;
    @(negedge clk); par_err = 1;
    @(negedge clk); par_err = 0;
    chk("R10 parity ignored when off", 32'(halted), 0);
    par_en = 1;
    @(negedge clk); par_err = 1;
    @(negedge clk); par_err = 0;
    par_en = 0;
    chk("R10 parity halts when on", 32'(halted), 1);
    chan_reset();
    enq_desc(2);
    rel_sts(2);
    cyc(5);
    @(negedge clk); sys_err = 1;
    @(negedge clk); sys_err = 0;
    chk("R10 sys err halts", 32'(halted), 1);
    chk("R9 irq on hard error", 32'(irq), 1);
    send_frame(2, 4, 4'h0, 32'h4000_0000);
    chk("R10 no write while halted", mem[8'h80], 32'h0);
    chk("R10 no request while halted", 32'(halted_reqs), 0);
    chan_reset();
    chk("R11 halt cleared", 32'(halted), 0);
    chk("R11 desc credit cleared", 32'(desc_cnt), 0);
    chk("R11 sts credit cleared", 32'(sts_cnt), 0);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    enq_desc(1);
    rel_sts(1);
    send_frame(1, 4, 4'h0, 32'h5000_0000);
    chk("R11 resumes at ring start", mem[8'h80], 32'h5000_0000);
    chk("R11 status slot restarts", mem[8'h40], sts_exp(0, 4'h0, 4));
    chan_reset();
    err_en = 1;
    enq_desc(1);
    cyc(5);
    chk("R10 bus abort halts", 32'(halted), 1);
    chk("R2 aborted read not counted", 32'(desc_cnt), 1);
    err_en = 0;
    chan_reset();
  endtask

  initial begin
    init_req = 1;
    cyc(3);
    rst_n = 1;
    @(negedge clk); init_req = 0;
    t_reset();
    t_credits();
    t_frames();
    t_soft_err();
    t_drop();
    t_irq();
    t_hard();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule